// File: doc/BRIEF.md
# Key Chord Reset Detector

This block turns a chord of push keys into a system reset request. Four active-high key lines enter from the pads. Each line passes through a two-flop synchroniser and a per-line stability filter before it is used. A static two-bit setting chooses which keys form the chord: none, keys 0 and 1, keys 0 to 2, or all four. When every chosen key is high at once, and stays high without a break for the hold window, the reset request goes high.

A second static bit chooses between two hold windows. With long-hold qualification on, the chord must last for a window in the one-to-three-second range (2 s by default). With it off, a hold of about 6 ms is enough. The block runs from a 32.768 kHz timebase clock, and every threshold is a parameter so that a test build can shorten it. An asynchronous active-high power-on reset clears all state.

Top module: `chord_reset_det`

## Requirements
- R1: `chord_sel` encodes the chord as follows: 0 = no chord, 1 = keys 0 and 1, 2 = keys 0, 1 and 2, 3 = keys 0, 1, 2 and 3. Bit i of `key_i` is key i.
- R2: With `chord_sel` = 0, no key pattern of any duration raises `rst_req_o` or `chord_o`.
- R3: A reset is requested only while all keys of the selected chord are accepted high together. Keys outside the chord have no effect, whether they are high or low.
- R4: With `long_hold_en` = 1, `rst_req_o` rises on the HOLD_LONG_CYC-th clock edge at which the filtered chord is present.
- R5: With `long_hold_en` = 0, `rst_req_o` rises on the HOLD_SHORT_CYC-th clock edge at which the filtered chord is present.
- R6: The hold time must be continuous. Once a selected key is accepted low, the count restarts from zero.
- R7: A key change is accepted 2 + DEB_CYC clock edges after it reaches the pin, and only if the new level is held for DEB_CYC edges after synchronisation. A pulse shorter than that is ignored.
- R8: Once raised, `rst_req_o` stays high while the filtered chord is present. It falls on the first clock edge after the chord is accepted as released.
- R9: `chord_o` is high exactly while the filtered key levels contain the full selected chord.
- R10: While `por` is high, `rst_req_o` and `chord_o` are low and all filters and counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| por | input | 1 | Asynchronous power-on reset, active high |
| key_i | input | 4 | Raw active-high key lines |
| chord_sel | input | 2 | Static chord selection (see R1) |
| long_hold_en | input | 1 | Static: 1 selects the long hold window, 0 the short one |
| rst_req_o | output | 1 | System reset request |
| chord_o | output | 1 | Status: filtered chord currently present |

## Verification
For the test build, DEB_CYC = 3, HOLD_SHORT_CYC = 5 and HOLD_LONG_CYC = 12. A key pattern applied at the pins shows on `chord_o` after 2 + DEB_CYC edges. It shows on `rst_req_o` after 2 + DEB_CYC + hold edges. A release clears `chord_o` after 2 + DEB_CYC edges and `rst_req_o` after one edge more. The bench drives and samples only on falling clock edges, and counts rising edges from each stimulus. It checks each output one edge before its due edge and again on that edge, so an early or a late change both count as a mismatch. The sweep covers every chord setting, both hold windows and all sixteen key patterns.

// File: rtl/chord_rst_pkg.sv
package chord_rst_pkg;

    localparam int unsigned KEY_LINES = 4;

    typedef logic [KEY_LINES-1:0] key_vec_t;

    typedef enum logic [1:0] {
        CHORD_NONE = 2'd0,
        CHORD_K01  = 2'd1,
        CHORD_K012 = 2'd2,
        CHORD_ALL  = 2'd3
    } chord_sel_e;

    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_COUNT = 2'd1,
        HOLD_FIRED = 2'd2
    } hold_state_e;

    // Which key lines take part in the chord for a given setting.
    function automatic key_vec_t chord_mask(chord_sel_e sel);
        key_vec_t m;
        case (sel)
            CHORD_K01:  m = 4'b0011;
            CHORD_K012: m = 4'b0111;
            CHORD_ALL:  m = 4'b1111;
            default:    m = 4'b0000;
        endcase
        return m;
    endfunction

    // The chord is present when the mask is not empty and every masked line is high.
    function automatic logic chord_hit(key_vec_t keys, key_vec_t mask);
        return (mask != '0) && ((keys & mask) == mask);
    endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync
    import chord_rst_pkg::*;
#(
    parameter int unsigned LINES = KEY_LINES
) (
    input  logic             clk,
    input  logic             por,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or posedge por) begin
            if (por) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= raw_i[g];
                stab_q <= meta_q;
            end
        end

        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/key_filter.sv
module key_filter
    import chord_rst_pkg::*;
#(
    parameter int unsigned LINES   = KEY_LINES,
    parameter int unsigned DEB_CYC = 8
) (
    input  logic             clk,
    input  logic             por,
    input  logic [LINES-1:0] sync_i,
    output logic [LINES-1:0] level_o
);

    localparam int unsigned DW       = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic          lvl_q;
        logic [DW-1:0] run_q;

        always_ff @(posedge clk or posedge por) begin
            if (por) begin
                lvl_q <= 1'b0;
                run_q <= '0;
            end else if (sync_i[g] == lvl_q) begin
                run_q <= '0;
            end else if (run_q == DEB_LAST) begin
                lvl_q <= sync_i[g];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end

        assign level_o[g] = lvl_q;
    end

endmodule

// File: rtl/chord_match.sv
module chord_match
    import chord_rst_pkg::*;
(
    input  key_vec_t   level_i,
    input  chord_sel_e sel_i,
    output logic       chord_o
);

    key_vec_t mask;

    always_comb begin
        mask    = chord_mask(sel_i);
        chord_o = chord_hit(level_i, mask);
    end

endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import chord_rst_pkg::*;
#(
    parameter int unsigned HOLD_SHORT_CYC = 197,
    parameter int unsigned HOLD_LONG_CYC  = 65536
) (
    input  logic clk,
    input  logic por,
    input  logic chord_i,
    input  logic long_i,
    output logic fire_o
);

    localparam int unsigned HMAX = (HOLD_LONG_CYC > HOLD_SHORT_CYC) ? HOLD_LONG_CYC : HOLD_SHORT_CYC;
    localparam int unsigned CW   = (HMAX < 2) ? 1 : $clog2(HMAX);
    localparam logic [CW-1:0] SHORT_LAST = CW'(HOLD_SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(HOLD_LONG_CYC - 1);

    hold_state_e   st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = long_i ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            st_q  <= HOLD_IDLE;
            cnt_q <= '0;
        end else if (!chord_i) begin
            st_q  <= HOLD_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                HOLD_IDLE, HOLD_COUNT: begin
                    if (cnt_q == last) begin
                        st_q <= HOLD_FIRED;
                    end else begin
                        st_q  <= HOLD_COUNT;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= HOLD_FIRED;
            endcase
        end
    end

    assign fire_o = (st_q == HOLD_FIRED);

endmodule

// File: rtl/chord_reset_det.sv
module chord_reset_det
    import chord_rst_pkg::*;
#(
    parameter int unsigned DEB_CYC        = 8,
    parameter int unsigned HOLD_SHORT_CYC = 197,
    parameter int unsigned HOLD_LONG_CYC  = 65536
) (
    input  logic       clk,
    input  logic       por,
    input  logic [3:0] key_i,
    input  logic [1:0] chord_sel,
    input  logic       long_hold_en,
    output logic       rst_req_o,
    output logic       chord_o
);

    key_vec_t key_sync_w;
    key_vec_t key_level_w;
    logic     chord_w;

    key_sync #(.LINES(KEY_LINES)) i_sync (
        .clk    (clk),
        .por    (por),
        .raw_i  (key_i),
        .sync_o (key_sync_w)
    );

    key_filter #(.LINES(KEY_LINES), .DEB_CYC(DEB_CYC)) i_filter (
        .clk     (clk),
        .por     (por),
        .sync_i  (key_sync_w),
        .level_o (key_level_w)
    );

    chord_match i_match (
        .level_i (key_level_w),
        .sel_i   (chord_sel_e'(chord_sel)),
        .chord_o (chord_w)
    );

    hold_timer #(
        .HOLD_SHORT_CYC (HOLD_SHORT_CYC),
        .HOLD_LONG_CYC  (HOLD_LONG_CYC)
    ) i_hold (
        .clk     (clk),
        .por     (por),
        .chord_i (chord_w),
        .long_i  (long_hold_en),
        .fire_o  (rst_req_o)
    );

    assign chord_o = chord_w;

endmodule

// File: rtl/chord_rst_chk.sv
module chord_rst_chk #(
    parameter int unsigned HOLD_SHORT_CYC = 197,
    parameter int unsigned HOLD_LONG_CYC  = 65536
) (
    input logic       clk,
    input logic       por,
    input logic [1:0] chord_sel,
    input logic       long_hold_en,
    input logic       rst_req_o,
    input logic       chord_o
);

    localparam int unsigned HMAX = (HOLD_LONG_CYC > HOLD_SHORT_CYC) ? HOLD_LONG_CYC : HOLD_SHORT_CYC;
    localparam int unsigned RW   = $clog2(HMAX + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or posedge por) begin
        if (por)                       run_q <= '0;
        else if (!chord_o)             run_q <= '0;
        else if (run_q != {RW{1'b1}})  run_q <= run_q + 1'b1;
    end

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (por)
        (chord_sel == 2'd0) |-> (!rst_req_o && !chord_o));

    // R9
    chord_needs_sel_chk: assert property (@(posedge clk) disable iff (por)
        chord_o |-> (chord_sel != 2'd0));

    // R4
    long_rise_chk: assert property (@(posedge clk) disable iff (por)
        ($rose(rst_req_o) && long_hold_en) |-> (32'(run_q) == HOLD_LONG_CYC));

    // R5
    short_rise_chk: assert property (@(posedge clk) disable iff (por)
        ($rose(rst_req_o) && !long_hold_en) |-> (32'(run_q) == HOLD_SHORT_CYC));

    // R8
    held_stays_chk: assert property (@(posedge clk) disable iff (por)
        (rst_req_o && chord_o) |=> rst_req_o);

    // R8
    release_drop_chk: assert property (@(posedge clk) disable iff (por)
        !chord_o |=> !rst_req_o);

    // R10
    always @(posedge clk) begin
        if (por) begin
            por_clear_chk: assert (!rst_req_o && !chord_o);
        end
    end

endmodule

bind chord_reset_det chord_rst_chk #(
    .HOLD_SHORT_CYC (HOLD_SHORT_CYC),
    .HOLD_LONG_CYC  (HOLD_LONG_CYC)
) i_chk (
    .clk          (clk),
    .por          (por),
    .chord_sel    (chord_sel),
    .long_hold_en (long_hold_en),
    .rst_req_o    (rst_req_o),
    .chord_o      (chord_o)
);

// File: tb/test_chord_reset_det.sv
module test_chord_reset_det;

    localparam time CLK_PERIOD = 30us;
    localparam int  DEB   = 3;
    localparam int  SHORT = 5;
    localparam int  LONG  = 12;
    localparam int  SEEN  = 2 + DEB;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic [3:0] key_i = 4'h0;
    logic [1:0] chord_sel = 2'd0;
    logic       long_hold_en = 1'b0;
    logic       rst_req_o;
    logic       chord_o;

    int n_cmp  = 0;
    int n_miss = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chord_reset_det #(
        .DEB_CYC        (DEB),
        .HOLD_SHORT_CYC (SHORT),
        .HOLD_LONG_CYC  (LONG)
    ) i_chord_reset_det (
        .clk          (clk),
        .por          (por),
        .key_i        (key_i),
        .chord_sel    (chord_sel),
        .long_hold_en (long_hold_en),
        .rst_req_o    (rst_req_o),
        .chord_o      (chord_o)
    );

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_miss++;
            $display("FAIL %s: got %0b expected %0b (sel=%0d long=%0b keys=%b)",
                     req, act, exp_v, chord_sel, long_hold_en, key_i);
        end
    endtask

    function automatic logic [3:0] mask_of(input logic [1:0] s);
        return 4'((1 << (s + 1)) - 1) & {4{s != 2'd0}};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        // R10: power-on reset clears everything even with a full chord applied
        chord_sel = 2'd3;
        key_i     = 4'hF;
        wait_edges(SEEN + SHORT + 3);
        check("R10 rst during por", rst_req_o, 1'b0);
        check("R10 chord during por", chord_o, 1'b0);
        key_i = 4'h0;
        wait_edges(2);
        por = 1'b0;
        wait_edges(SEEN + 2);
        check("R10 rst after por", rst_req_o, 1'b0);

        // R1 R2 R3 R4 R5 R8 R9: full sweep
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 2; l++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [3:0] m;
                    logic       hit;
                    int         thr;
                    chord_sel    = 2'(s);
                    long_hold_en = 1'(l);
                    m   = mask_of(2'(s));
                    hit = (m != 4'h0) && ((4'(p) & m) == m);
                    thr = l ? LONG : SHORT;
                    wait_edges(1);
                    key_i = 4'(p);
                    wait_edges(SEEN - 1);
                    check("R7 chord not early", chord_o, 1'b0);
                    wait_edges(1);
                    check("R9 R1 R3 chord status", chord_o, hit);
                    wait_edges(thr - 1);
                    check(l ? "R4 no early fire" : "R5 no early fire", rst_req_o, 1'b0);
                    wait_edges(1);
                    check(s == 0 ? "R2 disabled fire" : (l ? "R4 R3 fire" : "R5 R3 fire"),
                          rst_req_o, hit);
                    wait_edges(6);
                    check("R8 stays high", rst_req_o, hit);
                    key_i = 4'h0;
                    wait_edges(SEEN);
                    check("R9 chord released", chord_o, 1'b0);
                    check("R8 held until edge after release", rst_req_o, hit);
                    wait_edges(1);
                    check("R8 drop after release", rst_req_o, 1'b0);
                end
            end
        end

        // R7: short glitch on a chord is ignored
        chord_sel    = 2'd1;
        long_hold_en = 1'b0;
        wait_edges(1);
        key_i = 4'b0011;
        wait_edges(DEB - 1);
        key_i = 4'b0000;
        for (int i = 0; i < SEEN + SHORT + 4; i++) begin
            wait_edges(1);
            check("R7 glitch chord", chord_o, 1'b0);
            check("R7 glitch rst", rst_req_o, 1'b0);
        end

        // R6: a break in the chord restarts the hold count
        chord_sel    = 2'd3;
        long_hold_en = 1'b1;
        wait_edges(1);
        key_i = 4'hF;
        wait_edges(SEEN + 2);
        key_i = 4'hE;
        wait_edges(SEEN + 2);
        check("R6 chord broken", chord_o, 1'b0);
        check("R6 no rst on break", rst_req_o, 1'b0);
        key_i = 4'hF;
        wait_edges(SEEN + LONG - 1);
        check("R6 count restarted", rst_req_o, 1'b0);
        wait_edges(1);
        check("R6 fire after full hold", rst_req_o, 1'b1);
        key_i = 4'h0;
        wait_edges(SEEN + 1);
        check("R6 drop after release", rst_req_o, 1'b0);

        // R3: a key outside the chord dropping does not disturb a fired reset
        chord_sel    = 2'd1;
        long_hold_en = 1'b0;
        wait_edges(1);
        key_i = 4'hF;
        wait_edges(SEEN + SHORT);
        check("R3 fire with extras", rst_req_o, 1'b1);
        key_i = 4'h3;
        wait_edges(SEEN + 3);
        check("R3 extra drop ignored", rst_req_o, 1'b1);
        key_i = 4'h0;
        wait_edges(SEEN + 1);
        check("R8 final drop", rst_req_o, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule